// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

This block holds the register and pin logic of a small I/O expander port. A serial target outside the block decodes bus transfers into a simple register interface of select, read strobe, write strobe and data lines. The block keeps three writable registers: output levels, input polarity inversion and pin direction. It also presents an input-port value built from synchronized pin levels. Each pin gets a drive-enable and a drive level for an external pad. A separate drive-low enable serves an open-drain, active-low interrupt line.

The interrupt works by comparing levels. A snapshot register records the synchronized pin levels whenever the input register is read. The interrupt is requested while any pin configured as an input differs from its snapshot bit. It therefore drops either when that pin returns to its recorded level or when software reads the input register. The snapshot is primed with the real pin levels after reset, so no interrupt is pending when reset is released.

Top module: `gpx_port_core`

## Requirements
- R1: After `rst_n` is low, the output register is all ones, the polarity register is all zeros, the direction register is all ones, every `pin_oe` bit is 0 and `irq_drive_low` is 0.
- R2: With `reg_sel` = 0 (input register), `reg_rdata` bits N_PINS-1:0 are the pin levels seen after a SYNC_STAGES-flop synchronizer, each XORed with its polarity bit, whatever the pin direction. Bits above read 1.
- R3: A write with `reg_sel` = 0 changes no register: output, polarity and direction read back unchanged.
- R4: `reg_sel` = 1 selects the output register. It reads back the stored bits (unused upper bits read 1), not the pin levels, and `pin_out` carries the stored bits.
- R5: `reg_sel` = 2 selects the polarity register (unused upper bits read 0). A 1 bit inverts the matching input-register bit and a 0 bit leaves it as is.
- R6: `reg_sel` = 3 selects the direction register (unused upper bits read 1). A 1 bit makes the pin an input with `pin_oe` = 0, and a 0 bit makes it an output with `pin_oe` = 1.
- R7: `irq_drive_low` goes to 1 when a synchronized input-configured pin differs from its snapshot bit.
- R8: `irq_drive_low` returns to 0 when every such pin is back at its snapshot level.
- R9: A cycle with `reg_rd` = 1 and `reg_sel` = 0 loads the snapshot with the synchronized pins, and the interrupt is 0 in the next cycle if the pins hold still. Reads of other registers leave the snapshot alone.
- R10: Level changes on pins configured as outputs never raise the interrupt.
- R11: Turning an output pin into an input raises the interrupt, one cycle after the write, if its level differs from its snapshot bit.
- R12: After reset the interrupt stays 0 for SYNC_STAGES+1 cycles while the snapshot is primed from the synchronizer. From then on it follows R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, same effect as power-up |
| reg_sel | input | 2 | Register select: 0 input, 1 output, 2 polarity, 3 direction |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, marks a read transfer for snapshot capture |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the selected register, combinational |
| pin_in | input | N_PINS | Raw pin levels from the pads |
| pin_out | output | N_PINS | Drive levels for the pads |
| pin_oe | output | N_PINS | Drive enables, 1 drives the pad |
| irq_drive_low | output | 1 | 1 pulls the open-drain interrupt line low |

## Verification
The bench builds the block with its defaults: four pins, an 8-bit register width and a two-stage synchronizer. With four pins, a mix of input and output directions fits in one word, so output-pin changes, input-pin changes and direction flips can all be exercised in the same run. The 8-bit width leaves four unused upper bits whose fill values per register can be checked. The two-stage synchronizer makes the three-cycle arming window after reset short enough to check the interrupt one cycle at a time.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  typedef enum logic [1:0] {
    SEL_IN  = 2'd0,
    SEL_OUT = 2'd1,
    SEL_POL = 2'd2,
    SEL_CFG = 2'd3
  } gpx_sel_e;

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int N_PINS = 4,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [REG_W-1:0]  wdata,
  input  logic [N_PINS-1:0] pin_s,
  output logic [N_PINS-1:0] out_q,
  output logic [N_PINS-1:0] pol_q,
  output logic [N_PINS-1:0] cfg_q,
  output logic [REG_W-1:0]  rdata
);

  localparam int PAD_W = REG_W - N_PINS;

  // Widen a pin-wide value to a register word with a fixed fill above it.
  function automatic logic [REG_W-1:0] widen(input logic [N_PINS-1:0] v,
                                             input logic fill);
    logic [REG_W-1:0] r;
    r = fill ? '1 : '0;
    r[N_PINS-1:0] = v;
    return r;
  endfunction

  // Input-port view: synchronized level with per-bit polarity applied.
  function automatic logic [N_PINS-1:0] apply_pol(input logic [N_PINS-1:0] lvl,
                                                  input logic [N_PINS-1:0] inv);
    return lvl ^ inv;
  endfunction

  wire wr_out = wr && (sel == SEL_OUT);
  wire wr_pol = wr && (sel == SEL_POL);
  wire wr_cfg = wr && (sel == SEL_CFG);
  wire wr_in  = wr && (sel == SEL_IN);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[REG_W-1:N_PINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '1;
      pol_q <= '0;
      cfg_q <= '1;
    end else begin
      if (wr_out) out_q <= wdata[N_PINS-1:0];
      if (wr_pol) pol_q <= wdata[N_PINS-1:0];
      if (wr_cfg) cfg_q <= wdata[N_PINS-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_IN:  rdata = widen(apply_pol(pin_s, pol_q), 1'b1);
      SEL_OUT: rdata = widen(out_q, 1'b1);
      SEL_POL: rdata = widen(pol_q, 1'b0);
      default: rdata = widen(cfg_q, 1'b1);
    endcase
  end

  // R3: a write aimed at the input register leaves all writable state alone
  assert_input_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_in |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));

  // R4: the output register only moves on its own write
  assert_out_holds_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_out |=> $stable(out_q));

  // R6: the direction register only moves on its own write
  assert_cfg_holds_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(cfg_q));

endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
  parameter int N_PINS      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_s,
  input  logic [N_PINS-1:0] cfg,
  input  logic              snap_load,
  output logic              armed,
  output logic [N_PINS-1:0] pend,
  output logic              irq
);

  localparam int ARM_LIMIT = SYNC_STAGES + 1;
  localparam int CNT_W     = $clog2(ARM_LIMIT + 1);

  // Pins that count toward the interrupt: inputs whose level left the snapshot.
  function automatic logic [N_PINS-1:0] change_mask(input logic [N_PINS-1:0] lvl,
                                                    input logic [N_PINS-1:0] ref_lvl,
                                                    input logic [N_PINS-1:0] is_in);
    return (lvl ^ ref_lvl) & is_in;
  endfunction

  logic [CNT_W-1:0]  arm_cnt;
  logic [N_PINS-1:0] snap_q;

  assign armed = (arm_cnt == CNT_W'(ARM_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_cnt <= '0;
      snap_q  <= '0;
    end else begin
      if (!armed) arm_cnt <= arm_cnt + 1'b1;
      if (!armed || snap_load) snap_q <= pin_s;
    end
  end

  assign pend = change_mask(pin_s, snap_q, cfg);
  assign irq  = armed && (|pend);

  // R9: a snapshot load with quiet pins leaves nothing pending next cycle
  assert_read_clears_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snap_load |=> (!$stable(pin_s) || !irq));

  // R10: a new interrupt needs a moving input pin or a direction change
  assert_irq_needs_input_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |=> (!irq || !$stable(cfg) || !$stable(pin_s & cfg)));

  // R12: arming with settled pins starts with nothing pending
  assert_arm_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(armed) && $stable(pin_s)) |-> !irq);

endmodule

// File: rtl/gpx_port_core.sv
module gpx_port_core
  import gpx_pkg::*;
#(
  parameter int N_PINS      = 4,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq_drive_low
);

  logic [N_PINS-1:0] pin_s;
  logic [N_PINS-1:0] out_q;
  logic [N_PINS-1:0] pol_q;
  logic [N_PINS-1:0] cfg_q;
  logic [N_PINS-1:0] irq_pend;
  logic              irq_armed;

  // Named event: a read transfer of the input register.
  wire rd_input_evt = reg_rd && (reg_sel == SEL_IN);

  gpx_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_s)
  );

  gpx_regs #(.N_PINS(N_PINS), .REG_W(REG_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .pin_s (pin_s),
    .out_q (out_q),
    .pol_q (pol_q),
    .cfg_q (cfg_q),
    .rdata (reg_rdata)
  );

  gpx_irq #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_s     (pin_s),
    .cfg       (cfg_q),
    .snap_load (rd_input_evt),
    .armed     (irq_armed),
    .pend      (irq_pend),
    .irq       (irq_drive_low)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~cfg_q;

  // R10: with every pin driven as an output nothing can interrupt
  assert_all_out_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe == '1) |-> !irq_drive_low);

  // R7: an interrupt always has a pending input pin behind it
  assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_drive_low |-> (irq_pend != '0));

endmodule

// File: tb/gpx_port_core_bench.sv
module gpx_port_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_PINS = 4;
  localparam int REG_W  = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       reg_sel = 2'd0;
  logic             reg_wr = 1'b0;
  logic             reg_rd = 1'b0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic [N_PINS-1:0] pin_in = 4'b1010;
  logic [N_PINS-1:0] pin_out;
  logic [N_PINS-1:0] pin_oe;
  logic             irq_drive_low;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpx_port_core u_gpx_port_core (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_drive_low(irq_drive_low)
  );

  // Scoreboard item kinds: 0 read data, 1 interrupt, 2 drive enables, 3 drive levels
  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];
  item_t it;
  logic [7:0] got;

  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      case (it.kind)
        0: got = reg_rdata;
        1: got = {7'd0, irq_drive_low};
        2: got = {4'd0, pin_oe};
        default: got = {4'd0, pin_out};
      endcase
      checks++;
      if (got !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, got, it.exp);
      end
    end
  end

  // Bench model of the register state
  logic [3:0] m_out = 4'hF, m_pol = 4'h0, m_cfg = 4'hF, m_snap = 4'h0;

  function automatic logic [7:0] exp_input(input logic [3:0] pins, input logic [3:0] inv);
    return {4'hF, pins ^ inv};
  endfunction

  function automatic logic exp_irq(input logic [3:0] pins, input logic [3:0] snap,
                                   input logic [3:0] dir_in);
    return ((pins ^ snap) & dir_in) != 4'h0;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_and_wait(input int kind, input logic [7:0] exp, input string req);
    item_t x;
    x.kind = kind; x.exp = exp; x.req = req;
    sb_q.push_back(x);
    @(negedge clk);
    #1;
  endtask

  task automatic expect_reg(input logic [1:0] sel, input logic [7:0] exp, input string req);
    reg_sel = sel;
    reg_rd = 1'b0;
    push_and_wait(0, exp, req);
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [7:0] val);
    reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
    cyc(1);
    reg_wr = 1'b0;
    if (sel == 2'd1) m_out = val[3:0];
    if (sel == 2'd2) m_pol = val[3:0];
    if (sel == 2'd3) m_cfg = val[3:0];
  endtask

  task automatic read_strobe(input logic [1:0] sel);
    reg_sel = sel; reg_rd = 1'b1;
    cyc(1);
    reg_rd = 1'b0;
    if (sel == 2'd0) m_snap = pin_in;
  endtask

  task automatic set_pins(input logic [3:0] v);
    pin_in = v;
    cyc(3);
  endtask

  initial begin
    // R1 / R12: reset with pins 1010, snapshot primed from them
    cyc(3);
    rst_n = 1'b1;
    m_snap = pin_in;
    for (int k = 0; k < 3; k++) push_and_wait(1, 8'h00, "R12 arming window");
    cyc(2);
    expect_reg(2'd1, 8'hFF, "R1 output default");
    expect_reg(2'd2, 8'h00, "R1 polarity default");
    expect_reg(2'd3, 8'hFF, "R1 direction default");
    push_and_wait(2, 8'h00, "R1 drive enables off");
    push_and_wait(1, 8'h00, "R1 interrupt idle");
    expect_reg(2'd0, exp_input(pin_in, m_pol), "R2 input read");

    // R3: write to input register ignored
    write_reg(2'd0, 8'h00);
    expect_reg(2'd1, 8'hFF, "R3 output untouched");
    expect_reg(2'd2, 8'h00, "R3 polarity untouched");
    expect_reg(2'd3, 8'hFF, "R3 direction untouched");

    // R4: output register stores, reads stored bits not pins
    write_reg(2'd1, 8'h05);
    expect_reg(2'd1, {4'hF, m_out}, "R4 output readback");
    push_and_wait(3, {4'd0, m_out}, "R4 drive levels");
    expect_reg(2'd0, exp_input(pin_in, m_pol), "R4 input unaffected by output reg");

    // R5: polarity inversion
    write_reg(2'd2, 8'h0C);
    expect_reg(2'd2, 8'h0C, "R5 polarity readback");
    expect_reg(2'd0, exp_input(pin_in, m_pol), "R5 inverted input");
    write_reg(2'd2, 8'h00);

    // R6: pins 1:0 become outputs
    write_reg(2'd3, 8'h0C);
    expect_reg(2'd3, 8'hFC, "R6 direction readback");
    push_and_wait(2, 8'h03, "R6 drive enables");

    // R10 / R2: output pin moves, no interrupt, level still visible
    set_pins(4'b1011);
    push_and_wait(1, {7'd0, exp_irq(pin_in, m_snap, m_cfg)}, "R10 output pin change");
    expect_reg(2'd0, exp_input(pin_in, m_pol), "R2 output pin visible");

    // R7 / R8: input pin 2 toggles away and back
    set_pins(4'b1111);
    push_and_wait(1, 8'h01, "R7 input change raises");
    set_pins(4'b1011);
    push_and_wait(1, 8'h00, "R8 return releases");
    set_pins(4'b1111);
    push_and_wait(1, 8'h01, "R7 second change");
    read_strobe(2'd1);
    push_and_wait(1, 8'h01, "R9 other read keeps interrupt");
    read_strobe(2'd0);
    push_and_wait(1, 8'h00, "R9 input read clears");

    // R10 / R11: output pin 1 drops, then becomes input
    set_pins(4'b1101);
    push_and_wait(1, {7'd0, exp_irq(pin_in, m_snap, m_cfg)}, "R10 output pin drop");
    write_reg(2'd3, 8'h0E);
    push_and_wait(1, {7'd0, exp_irq(pin_in, m_snap, m_cfg)}, "R11 direction flip raises");

    // R12: reset mid-run with pins differing from old snapshot
    rst_n = 1'b0;
    pin_in = 4'b0110;
    cyc(2);
    rst_n = 1'b1;
    m_out = 4'hF; m_pol = 4'h0; m_cfg = 4'hF; m_snap = pin_in;
    for (int k = 0; k < 5; k++) push_and_wait(1, 8'h00, "R12 no interrupt after reset");
    expect_reg(2'd3, 8'hFF, "R1 direction after reset");
    set_pins(4'b0111);
    push_and_wait(1, 8'h01, "R12 armed after window");

    cyc(2);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule